// File: doc/BRIEF.md
# D-PHY Receiver Bring-Up Sequencer

This block brings up a camera-side D-PHY receiver. A pulse on `start_i` latches a line rate in Mbps and a lane-select field. If either of them is zero, the receiver is put into standby. In standby the PHY is held in shutdown and reset, the controller lane enables are cleared, and no PHY register is touched. For any other values the block maps the rate to a frequency-band code and holds the PHY in shutdown and reset. It then pulses the test-clear line and walks a fixed list of PHY test-port writes through an external write engine. Finally it releases the PHY.

The write engine, which serialises each access onto the PHY test port, sits outside this block. Each access is offered on `wr_req_o` with an address, a data byte and a flag that says whether a data phase follows. The access is retired when the engine pulses `wr_done_i`. Rates that fall in no band still bring the PHY up, using code zero, and raise `rate_err_o` until the next start.

Top module: `dphy_rx_bringup`

## Requirements
- R1: A start with rate 0 or lane field 0 causes no write request. It drives `shutdown_n_o`, `reset_n_o` and all four bits of `ctrl_lane_en_o` low, clears `rate_err_o`, and pulses `done_o` in the cycle after the start.
- R2: A rate matches a band when it is above the band's lower edge and at or below its upper edge. Bands span 80 to 1000 Mbps. Six example bands and their codes:
  - (80,90] gives 0x00
  - (90,100] gives 0x10
  - (110,130] gives 0x01
  - (250,270] gives 0x04
  - (800,850] gives 0x29
  - (950,1000] gives 0x1A
- R3: A nonzero rate of 80 or less, or above 1000, sets `rate_err_o` to 1 and uses code 0x00. Any supported rate sets `rate_err_o` to 0.
- R4: Every lane-rate write carries the band code shifted left by one bit, so its bit 0 is always 0.
- R5: `shutdown_n_o` and `reset_n_o` are low whenever `test_clr_o` is high. `test_clr_o` pulses high before the first write request of an active bring-up.
- R6: The first write goes to address 0x34 with data 0x15. The second goes to address 0x44 with the shifted code.
- R7: Address 0x54 is written next when the lane field is at least 1. Addresses 0x84 and then 0x94 follow when the lane field is at least 4. All three carry the shifted code.
- R8: The last access goes to address 0x00 with `wr_has_data_o` = 0. After it, `test_clk_o` is 1, `test_en_o` is 0, and `shutdown_n_o` and `reset_n_o` are 1. `ctrl_lane_en_o` is 0xF, and `phy_lane_en_o` equals the lane field.
- R9: After an active start, `turn_dis_o` is 0xF and `turn_req_o` is 0.
- R10: `done_o` is a single-cycle pulse per start. `busy_o` is high from the cycle after an active start until done. A start while busy is ignored.
- R11: `wr_req_o` stays high, with a stable address and data, until `wr_done_i`. It drops for at least one cycle between accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe |
| rate_mbps_i | input | RATE_W | Line rate in Mbps |
| lane_sel_i | input | LANE_W | Lane-select field |
| busy_o | output | 1 | Bring-up in progress |
| done_o | output | 1 | Completion pulse |
| rate_err_o | output | 1 | Rate outside every band |
| wr_req_o | output | 1 | Test-port access request |
| wr_addr_o | output | 8 | Test-port register address |
| wr_data_o | output | 8 | Test-port write data |
| wr_has_data_o | output | 1 | Data phase follows the address |
| wr_done_i | input | 1 | Access retired by the engine |
| test_clr_o | output | 1 | Test-port clear |
| test_clk_o | output | 1 | Static test-clock level |
| test_en_o | output | 1 | Test-enable level |
| shutdown_n_o | output | 1 | PHY shutdown, active low |
| reset_n_o | output | 1 | PHY reset, active low |
| phy_lane_en_o | output | LANE_W | PHY data-lane enables |
| turn_dis_o | output | 4 | Per-lane turnaround disable |
| turn_req_o | output | 4 | Per-lane turnaround request |
| ctrl_lane_en_o | output | 4 | Controller lane enables |

## Verification
The bench sweeps every rate from 0 to 1023 and then the top of the input range. It compares the band edges exactly: a design that used `>=` on the lower edge would map 90 to 0x10 instead of 0x00, and would accept 80 instead of flagging it. A wrong `rate_err_o` on 1000 or 1001 exposes an off-by-one on the upper edge. A design that forgot the shift would put odd codes such as 0x01 on the wire.

All sixteen lane-field values are tried. This catches a design that compares against 4 with the wrong relation and so gains or loses the 0x84/0x94 pair, and one that writes lanes for a zero field. A second start fired in the middle of a bring-up must leave the write list and the final pin levels untouched. A start with zero rate after a finished bring-up must pull shutdown, reset and the controller enables back down.

// File: rtl/dphy_bringup_pkg.sv
package dphy_bringup_pkg;

  localparam int unsigned NUM_BANDS = 29;

  // band n covers (BAND_EDGE[n], BAND_EDGE[n+1]]
  localparam int unsigned BAND_EDGE [NUM_BANDS+1] = '{
    80, 90, 100, 110, 130, 140, 150, 170, 180, 200,
    220, 240, 250, 270, 300, 330, 360, 400, 450, 500,
    550, 600, 650, 700, 750, 800, 850, 900, 950, 1000
  };

  localparam logic [7:0] BAND_CODE [NUM_BANDS] = '{
    8'h00, 8'h10, 8'h20, 8'h01, 8'h11, 8'h21, 8'h02, 8'h12, 8'h22, 8'h03,
    8'h13, 8'h23, 8'h04, 8'h14, 8'h05, 8'h15, 8'h25, 8'h06, 8'h16, 8'h07,
    8'h17, 8'h08, 8'h18, 8'h09, 8'h19, 8'h29, 8'h39, 8'h0a, 8'h1a
  };

  localparam logic [7:0] A_CLK_LANE = 8'h34;
  localparam logic [7:0] D_CLK_LANE = 8'h15;
  localparam logic [7:0] A_LANE0    = 8'h44;
  localparam logic [7:0] A_LANE1    = 8'h54;
  localparam logic [7:0] A_LANE2    = 8'h84;
  localparam logic [7:0] A_LANE3    = 8'h94;
  localparam logic [7:0] A_PARK     = 8'h00;

  localparam int unsigned HI_LANE_MIN = 4;
  localparam int unsigned NUM_WR      = 6;
  localparam int unsigned WR_IDX_W    = $clog2(NUM_WR + 1);

  typedef struct packed {
    logic       vld;
    logic [7:0] addr;
    logic [7:0] data;
    logic       has_data;
  } wr_ent_t;

  typedef enum logic [2:0] {
    S_IDLE, S_PREP, S_CLR, S_GAP, S_NXT, S_REQ, S_FIN
  } seq_st_t;

endpackage

// File: rtl/dphy_band_lut.sv
module dphy_band_lut
  import dphy_bringup_pkg::*;
#(
  parameter int unsigned RATE_W = 11
) (
  input  logic [RATE_W-1:0] rate_i,
  output logic [7:0]        code_sh_o,
  output logic              hit_o
);

  logic [31:0] rate32;
  logic [7:0]  code;

  assign rate32 = 32'(rate_i);

  always_comb begin
    hit_o = 1'b0;
    code  = 8'h00;
    for (int unsigned b = 0; b < NUM_BANDS; b++) begin
      if (rate32 > BAND_EDGE[b] && rate32 <= BAND_EDGE[b+1]) begin
        hit_o = 1'b1;
        code  = BAND_CODE[b];
      end
    end
  end

  assign code_sh_o = {code[6:0], 1'b0};

endmodule

// File: rtl/dphy_wr_list.sv
module dphy_wr_list
  import dphy_bringup_pkg::*;
#(
  parameter int unsigned LANE_W = 4
) (
  input  logic [WR_IDX_W-1:0] idx_i,
  input  logic [LANE_W-1:0]   lanes_i,
  input  logic [7:0]          code_sh_i,
  output wr_ent_t             ent_o
);

  logic has_l1, has_hi;

  assign has_l1 = (lanes_i >= LANE_W'(1));
  assign has_hi = (lanes_i >= LANE_W'(HI_LANE_MIN));

  always_comb begin
    ent_o = '{vld: 1'b0, addr: 8'h00, data: 8'h00, has_data: 1'b1};
    case (idx_i)
      WR_IDX_W'(0): ent_o = '{vld: 1'b1,   addr: A_CLK_LANE, data: D_CLK_LANE, has_data: 1'b1};
      WR_IDX_W'(1): ent_o = '{vld: 1'b1,   addr: A_LANE0,    data: code_sh_i,  has_data: 1'b1};
      WR_IDX_W'(2): ent_o = '{vld: has_l1, addr: A_LANE1,    data: code_sh_i,  has_data: 1'b1};
      WR_IDX_W'(3): ent_o = '{vld: has_hi, addr: A_LANE2,    data: code_sh_i,  has_data: 1'b1};
      WR_IDX_W'(4): ent_o = '{vld: has_hi, addr: A_LANE3,    data: code_sh_i,  has_data: 1'b1};
      WR_IDX_W'(5): ent_o = '{vld: 1'b1,   addr: A_PARK,     data: 8'h00,      has_data: 1'b0};
      default:      ent_o = '{vld: 1'b0,   addr: 8'h00,      data: 8'h00,      has_data: 1'b1};
    endcase
  end

endmodule

// File: rtl/dphy_seq_fsm.sv
module dphy_seq_fsm
  import dphy_bringup_pkg::*;
#(
  parameter int unsigned LANE_W  = 4,
  parameter int unsigned CLR_CYC = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                stby_i,
  input  logic                hit_i,
  input  logic [7:0]          code_sh_i,
  input  logic [LANE_W-1:0]   lanes_i,
  input  wr_ent_t             ent_i,
  input  logic                wr_done_i,
  output logic [WR_IDX_W-1:0] idx_o,
  output logic [7:0]          code_sh_o,
  output logic [LANE_W-1:0]   lanes_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                rate_err_o,
  output logic                wr_req_o,
  output logic                test_clr_o,
  output logic                test_clk_o,
  output logic                test_en_o,
  output logic                shutdown_n_o,
  output logic                reset_n_o,
  output logic [LANE_W-1:0]   phy_lane_en_o,
  output logic [3:0]          turn_dis_o,
  output logic [3:0]          turn_req_o,
  output logic [3:0]          ctrl_lane_en_o
);

  localparam int unsigned CNT_W = $clog2(CLR_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLR_CYC - 1);

  seq_st_t         st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q           <= S_IDLE;
      cnt_q          <= '0;
      idx_o          <= '0;
      code_sh_o      <= '0;
      lanes_o        <= '0;
      busy_o         <= 1'b0;
      done_o         <= 1'b0;
      rate_err_o     <= 1'b0;
      wr_req_o       <= 1'b0;
      test_clr_o     <= 1'b0;
      test_clk_o     <= 1'b0;
      test_en_o      <= 1'b0;
      shutdown_n_o   <= 1'b0;
      reset_n_o      <= 1'b0;
      phy_lane_en_o  <= '0;
      turn_dis_o     <= '0;
      turn_req_o     <= '0;
      ctrl_lane_en_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        S_IDLE: begin
          if (start_i) begin
            shutdown_n_o <= 1'b0;
            reset_n_o    <= 1'b0;
            if (stby_i) begin
              ctrl_lane_en_o <= '0;
              rate_err_o     <= 1'b0;
              done_o         <= 1'b1;
            end else begin
              busy_o        <= 1'b1;
              code_sh_o     <= code_sh_i;
              rate_err_o    <= !hit_i;
              lanes_o       <= lanes_i;
              phy_lane_en_o <= lanes_i;
              turn_dis_o    <= 4'hf;
              turn_req_o    <= 4'h0;
              st_q          <= S_PREP;
            end
          end
        end
        S_PREP: begin
          test_clk_o <= 1'b1;
          test_clr_o <= 1'b1;
          cnt_q      <= '0;
          st_q       <= S_CLR;
        end
        S_CLR: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_LAST) begin
            test_clr_o <= 1'b0;
            cnt_q      <= '0;
            st_q       <= S_GAP;
          end
        end
        S_GAP: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_LAST) begin
            idx_o <= '0;
            st_q  <= S_NXT;
          end
        end
        S_NXT: begin
          // skip list entries the lane field disables
          if (idx_o == WR_IDX_W'(NUM_WR)) begin
            st_q <= S_FIN;
          end else if (ent_i.vld) begin
            wr_req_o  <= 1'b1;
            test_en_o <= 1'b1;
            st_q      <= S_REQ;
          end else begin
            idx_o <= idx_o + 1'b1;
          end
        end
        S_REQ: begin
          if (wr_done_i) begin
            wr_req_o <= 1'b0;
            idx_o    <= idx_o + 1'b1;
            st_q     <= S_NXT;
          end
        end
        S_FIN: begin
          test_clk_o     <= 1'b1;
          test_en_o      <= 1'b0;
          shutdown_n_o   <= 1'b1;
          reset_n_o      <= 1'b1;
          ctrl_lane_en_o <= 4'hf;
          busy_o         <= 1'b0;
          done_o         <= 1'b1;
          st_q           <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  p_req_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && !wr_done_i |=> wr_req_o && $stable(ent_i.addr) && $stable(ent_i.data));
  p_req_gap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && wr_done_i |=> !wr_req_o);
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_req_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> busy_o);
  p_clr_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_clr_o |-> !shutdown_n_o && !reset_n_o);
  p_release_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(shutdown_n_o) |-> done_o && reset_n_o && !test_en_o);
  p_code_lsb_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && ent_i.has_data && ent_i.addr != A_CLK_LANE |-> !ent_i.data[0]);

endmodule

// File: rtl/dphy_rx_bringup.sv
module dphy_rx_bringup
  import dphy_bringup_pkg::*;
#(
  parameter int unsigned RATE_W  = 11,
  parameter int unsigned LANE_W  = 4,
  parameter int unsigned CLR_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [RATE_W-1:0] rate_mbps_i,
  input  logic [LANE_W-1:0] lane_sel_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              rate_err_o,
  output logic              wr_req_o,
  output logic [7:0]        wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              wr_has_data_o,
  input  logic              wr_done_i,
  output logic              test_clr_o,
  output logic              test_clk_o,
  output logic              test_en_o,
  output logic              shutdown_n_o,
  output logic              reset_n_o,
  output logic [LANE_W-1:0] phy_lane_en_o,
  output logic [3:0]        turn_dis_o,
  output logic [3:0]        turn_req_o,
  output logic [3:0]        ctrl_lane_en_o
);

  logic [7:0]          lut_code_sh, code_sh_q;
  logic                lut_hit, stby;
  logic [WR_IDX_W-1:0] idx;
  logic [LANE_W-1:0]   lanes_q;
  wr_ent_t             ent;

  assign stby = (rate_mbps_i == '0) || (lane_sel_i == '0);

  dphy_band_lut #(.RATE_W(RATE_W)) i_lut (
    .rate_i    (rate_mbps_i),
    .code_sh_o (lut_code_sh),
    .hit_o     (lut_hit)
  );

  dphy_wr_list #(.LANE_W(LANE_W)) i_list (
    .idx_i     (idx),
    .lanes_i   (lanes_q),
    .code_sh_i (code_sh_q),
    .ent_o     (ent)
  );

  dphy_seq_fsm #(.LANE_W(LANE_W), .CLR_CYC(CLR_CYC)) i_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start_i),
    .stby_i         (stby),
    .hit_i          (lut_hit),
    .code_sh_i      (lut_code_sh),
    .lanes_i        (lane_sel_i),
    .ent_i          (ent),
    .wr_done_i      (wr_done_i),
    .idx_o          (idx),
    .code_sh_o      (code_sh_q),
    .lanes_o        (lanes_q),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .rate_err_o     (rate_err_o),
    .wr_req_o       (wr_req_o),
    .test_clr_o     (test_clr_o),
    .test_clk_o     (test_clk_o),
    .test_en_o      (test_en_o),
    .shutdown_n_o   (shutdown_n_o),
    .reset_n_o      (reset_n_o),
    .phy_lane_en_o  (phy_lane_en_o),
    .turn_dis_o     (turn_dis_o),
    .turn_req_o     (turn_req_o),
    .ctrl_lane_en_o (ctrl_lane_en_o)
  );

  assign wr_addr_o     = ent.addr;
  assign wr_data_o     = ent.data;
  assign wr_has_data_o = ent.has_data;

  p_stby_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && stby |=> done_o && !wr_req_o && !shutdown_n_o && ctrl_lane_en_o == 4'h0);

endmodule

// File: tb/test_dphy_rx_bringup.sv
module test_dphy_rx_bringup;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [10:0] rate = '0;
  logic [3:0]  lanes = '0;
  logic        wr_done = 1'b0;
  logic        busy, done, rate_err, wr_req, wr_has_data;
  logic [7:0]  wr_addr, wr_data;
  logic        test_clr, test_clk, test_en, shutdown_n, reset_n;
  logic [3:0]  phy_lane_en, turn_dis, turn_req, ctrl_lane_en;

  int checks = 0, fails = 0;
  int lg_n = 0;
  logic [7:0] lg_addr [8];
  logic [7:0] lg_data [8];
  logic       lg_hd [8];
  int clr_seen = 0, clr_first = 0, clr_bad = 0, done_cnt = 0, eng_cnt = 0, nobusy_req = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dphy_rx_bringup i_dphy_rx_bringup (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rate_mbps_i(rate), .lane_sel_i(lanes),
    .busy_o(busy), .done_o(done), .rate_err_o(rate_err), .wr_req_o(wr_req),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_has_data_o(wr_has_data), .wr_done_i(wr_done),
    .test_clr_o(test_clr), .test_clk_o(test_clk), .test_en_o(test_en),
    .shutdown_n_o(shutdown_n), .reset_n_o(reset_n), .phy_lane_en_o(phy_lane_en),
    .turn_dis_o(turn_dis), .turn_req_o(turn_req), .ctrl_lane_en_o(ctrl_lane_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  // write engine model and monitor
  initial forever begin
    @(negedge clk);
    if (done) done_cnt++;
    if (test_clr) begin
      clr_seen = 1;
      if (shutdown_n || reset_n) clr_bad++;
    end
    if (wr_done) wr_done = 1'b0;
    else if (wr_req) begin
      if (!busy) nobusy_req++;
      eng_cnt++;
      if (eng_cnt == 2) begin
        if (lg_n == 0) clr_first = clr_seen;
        if (lg_n < 8) begin
          lg_addr[lg_n] = wr_addr;
          lg_data[lg_n] = wr_data;
          lg_hd[lg_n]   = wr_has_data;
        end
        lg_n++;
        wr_done = 1'b1;
        eng_cnt = 0;
      end
    end
  end

  // -1: not one of the example bands, else expected unshifted code
  function automatic int exp_code(input int r);
    int lo [6] = '{80, 90, 110, 250, 800, 950};
    int hi [6] = '{90, 100, 130, 270, 850, 1000};
    int cd [6] = '{'h00, 'h10, 'h01, 'h04, 'h29, 'h1a};
    if (r <= 80 || r > 1000) return 0;
    for (int k = 0; k < 6; k++) if (r > lo[k] && r <= hi[k]) return cd[k];
    return -1;
  endfunction

  task automatic run(input int r, input int l, input bit poke);
    bit got = 0;
    @(negedge clk);
    rate = 11'(r); lanes = 4'(l); start = 1'b1;
    lg_n = 0; clr_seen = 0; clr_first = 0; clr_bad = 0; done_cnt = 0; nobusy_req = 0;
    @(negedge clk);
    start = 1'b0;
    if (r != 0 && l != 0) chk(busy == 1'b1, "R10 busy after start", busy, 1);
    for (int c = 0; c < 2000; c++) begin
      if (done) begin got = 1; break; end
      if (poke && c == 6) begin
        rate = 11'd0; lanes = 4'd0; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk(got, "R10 done reached", got, 1);
  endtask

  task automatic post_done();
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, "R10 single done pulse", done_cnt, 1);
    chk(busy == 1'b0, "R10 idle after done", busy, 0);
  endtask

  task automatic check_active(input int r, input int l);
    int ec = exp_code(r);
    bit unsup = (r <= 80 || r > 1000);
    int n = 0;
    logic [7:0] ea [8];
    logic [7:0] ed [8];
    ea[n] = 8'h34; ed[n] = 8'h15; n++;
    ea[n] = 8'h44; ed[n] = 8'h00; n++;
    if (l >= 1) begin ea[n] = 8'h54; ed[n] = 8'h00; n++; end
    if (l >= 4) begin ea[n] = 8'h84; ed[n] = 8'h00; n++; ea[n] = 8'h94; ed[n] = 8'h00; n++; end
    ea[n] = 8'h00; ed[n] = 8'h00; n++;
    chk(lg_n == n, "R7 write count", lg_n, n);
    chk(rate_err == unsup, "R3 rate_err", rate_err, int'(unsup));
    chk(clr_first == 1 && clr_bad == 0, "R5 clear pulse under reset", clr_bad, 0);
    chk(nobusy_req == 0, "R10 request only while busy", nobusy_req, 0);
    if (lg_n == n) begin
      for (int k = 0; k < n; k++)
        chk(lg_addr[k] == ea[k], "R6/R7 write address order", lg_addr[k], ea[k]);
      chk(lg_data[0] == 8'h15, "R6 clock lane data", lg_data[0], 8'h15);
      for (int k = 1; k < n - 1; k++) begin
        chk(lg_data[k] == lg_data[1], "R7 same code on all lanes", lg_data[k], lg_data[1]);
        chk(lg_hd[k] == 1'b1, "R7 data phase", lg_hd[k], 1);
      end
      chk(lg_data[1][0] == 1'b0, "R4 shifted code bit0", lg_data[1], 0);
      if (ec >= 0) chk(lg_data[1] == 8'(ec << 1), "R2 band code", lg_data[1], ec << 1);
      if (unsup) chk(lg_data[1] == 8'h00, "R3 unsupported code", lg_data[1], 0);
      chk(lg_addr[n-1] == 8'h00 && lg_hd[n-1] == 1'b0, "R8 address-only park", lg_hd[n-1], 0);
    end
    chk(test_clk && !test_en, "R8 test clk/en final", {test_clk, test_en}, 2);
    chk(shutdown_n && reset_n, "R8 released", {shutdown_n, reset_n}, 3);
    chk(ctrl_lane_en == 4'hf, "R8 controller lanes", ctrl_lane_en, 'hf);
    chk(phy_lane_en == 4'(l), "R8 phy lanes", phy_lane_en, l);
    chk(turn_dis == 4'hf && turn_req == 4'h0, "R9 turnaround", {turn_dis, turn_req}, 'hf0);
  endtask

  task automatic check_stby();
    chk(lg_n == 0, "R1 no writes", lg_n, 0);
    chk(!shutdown_n && !reset_n, "R1 shutdown/reset low", {shutdown_n, reset_n}, 0);
    chk(ctrl_lane_en == 4'h0, "R1 controller lanes cleared", ctrl_lane_en, 0);
    chk(rate_err == 1'b0, "R1 no rate error", rate_err, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !wr_req && !shutdown_n && !reset_n && ctrl_lane_en == 0,
        "R1 reset state", {busy, done, wr_req, shutdown_n}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // rate sweep, one lane
    for (int r = 0; r < 1024; r++) begin
      run(r, 1, 0);
      post_done();
      if (r == 0) check_stby(); else check_active(r, 1);
    end
    run(2047, 2, 0); post_done(); check_active(2047, 2);

    // lane sweep at a known band
    for (int l = 0; l < 16; l++) begin
      run(95, l, 0);
      post_done();
      if (l == 0) check_stby(); else check_active(95, l);
    end

    // start while busy must be ignored (R10)
    run(830, 5, 1);
    post_done();
    check_active(830, 5);
    repeat (10) @(negedge clk);
    chk(done_cnt == 1 && shutdown_n, "R10 ignored start while busy", done_cnt, 1);

    // standby after an active bring-up (R1)
    run(0, 7, 0); post_done(); check_stby();
    run(830, 5, 0); post_done();
    run(500, 0, 0); post_done(); check_stby();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule